// File: doc/BRIEF.md
# Exception Entry Sequencer with Banked Mode Registers

This block keeps the processor's stack pointer (r29), link register (r30) and saved-status register as live copies, plus one private copy of each for every register bank. It has two jobs. The first is the bank swap when software changes the processor mode. The second is the whole exception entry. On entry it swaps the banks, saves the status word, forms the new status word, stores the return address and produces the vector address for the fetch stage.

The core presents an exception request with a 3-bit type, together with its current program counter and status word and a high-vectors control bit. In the next cycle the block shows the vector address, the new status word and a one-cycle fetch flush. A software mode change swaps the banks and nothing else. The core updates its own status word afterwards. A small write port lets the rest of the core update the live copies. A request that cannot be served raises a one-cycle error pulse and changes nothing.

Top module: `exc_bank_unit`

## Requirements
- R1: During and after reset, curSp, curLr, curSaved, newPc and newStatus read zero, and fetchFlush and errPulse are low.
- R2: Mode codes sit in status bits [2:0]. User (0) and system-user (7) share bank 0. Privileged (3) uses bank 1, trap (4) bank 2, extension (5) bank 3 and interrupt (2) bank 4. Codes 1 and 6 are invalid.
- R3: A mode request to a mode in a different bank stores the live r29, r30 and saved status into the bank of the current mode, and loads the live copies from the bank of the requested mode. The new values are visible the cycle after the request edge.
- R4: A mode request whose target uses the current bank leaves all live and banked values unchanged.
- R5: Exception type 0 (privileged call) enters privileged mode at offset 0x08. Type 1 (instruction trap) enters trap mode at 0x0C. Type 2 (data trap) enters trap mode at 0x10. Type 3 (interrupt) enters interrupt mode at 0x18.
- R6: When highVec is high at the request edge, 0xFFFF0000 is added to the vector address on newPc.
- R7: On entry, curSp is loaded from the target mode's bank after the outgoing values are banked. curSaved takes the incoming status word and curLr takes the incoming program counter. newStatus is the incoming status word with bits [2:0] set to the target mode and bit 7 (interrupt disable) set.
- R8: fetchFlush is high for exactly the one cycle after each accepted exception edge.
- R9: Any of the following raises errPulse for one cycle, with no flush and no change to any live, banked or output value: exception type 4 to 7, a current mode code of 1 or 6 when an exception or mode request arrives, or a requested mode code of 1 or 6.
- R10: When several requests arrive together, an exception request wins over a mode request, and a mode request wins over a register write. The losing requests have no effect.
- R11: A register write with regWrSel 0, 1 or 2 replaces the live r29, r30 or saved status in the next cycle. regWrSel 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excValid | input | 1 | Exception entry request |
| excType | input | 3 | Exception type code |
| curPc | input | 32 | Program counter to preserve in r30 |
| curStatus | input | 32 | Current status word; bits [2:0] hold the mode |
| highVec | input | 1 | Relocate vectors to the high base |
| modeReq | input | 1 | Software mode change request |
| modeNew | input | 3 | Requested mode code |
| regWrEn | input | 1 | Write to a live register |
| regWrSel | input | 2 | 0 r29, 1 r30, 2 saved status, 3 none |
| regWrData | input | 32 | Write data |
| curSp | output | 32 | Live r29 |
| curLr | output | 32 | Live r30 |
| curSaved | output | 32 | Live saved-status register |
| newPc | output | 32 | Vector address from the last entry |
| newStatus | output | 32 | Status word from the last entry |
| fetchFlush | output | 1 | One-cycle flush to the fetch stage |
| errPulse | output | 1 | One-cycle error on an unserviceable request |

## Verification
A bad live register shows up at curSp, curLr or curSaved in the cycle after the faulty edge. A bad banked copy stays hidden until a later swap or exception brings that bank back into use. The bench therefore stores distinct data in every bank and then crosses every pair of modes, so that each banked value is read back through the live ports. A wrong bank-index decode shows up as another mode's data on the first return to that mode. A wrong vector, a wrong mode field or a missing interrupt-disable bit shows on newPc, newStatus and fetchFlush in the cycle after the request.

// File: rtl/exc_bank_pkg.sv
package exc_bank_pkg;
  localparam int MODE_W      = 3;
  localparam int TYPE_W      = 3;
  localparam int BANK_CNT    = 5;
  localparam int BANK_IDX_W  = $clog2(BANK_CNT);
  localparam int VEC_W       = 8;
  localparam int IRQ_OFF_BIT = 7;

  // mode codes held in status[MODE_W-1:0]
  localparam logic [MODE_W-1:0] MODE_USER    = 3'd0;
  localparam logic [MODE_W-1:0] MODE_INTR    = 3'd2;
  localparam logic [MODE_W-1:0] MODE_PRIV    = 3'd3;
  localparam logic [MODE_W-1:0] MODE_TRAP    = 3'd4;
  localparam logic [MODE_W-1:0] MODE_EXTN    = 3'd5;
  localparam logic [MODE_W-1:0] MODE_SYSUSER = 3'd7;

  // exception type codes
  localparam logic [TYPE_W-1:0] EXC_PRIV_CALL = 3'd0;
  localparam logic [TYPE_W-1:0] EXC_ITRAP     = 3'd1;
  localparam logic [TYPE_W-1:0] EXC_DTRAP     = 3'd2;
  localparam logic [TYPE_W-1:0] EXC_IRQ       = 3'd3;

  typedef struct packed {
    logic                  ok;
    logic [BANK_IDX_W-1:0] idx;
  } bankSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                  enterExc;
    logic                  swapBanks;
    logic                  writeLive;
    logic                  raiseErr;
    logic [BANK_IDX_W-1:0] oldBank;
    logic [BANK_IDX_W-1:0] newBank;
    logic [MODE_W-1:0]     entryMode;
    logic [VEC_W-1:0]      vecOffset;
  } ctrlStrobe_t;

  function automatic bankSel_t bankOfMode(input logic [MODE_W-1:0] mode);
    bankSel_t sel;
    sel.ok = 1'b1;
    case (mode)
      MODE_USER, MODE_SYSUSER: sel.idx = BANK_IDX_W'(0);
      MODE_PRIV:               sel.idx = BANK_IDX_W'(1);
      MODE_TRAP:               sel.idx = BANK_IDX_W'(2);
      MODE_EXTN:               sel.idx = BANK_IDX_W'(3);
      MODE_INTR:               sel.idx = BANK_IDX_W'(4);
      default: begin
        sel.ok  = 1'b0;
        sel.idx = '0;
      end
    endcase
    return sel;
  endfunction
endpackage

// File: rtl/exc_bank_ctrl.sv
module exc_bank_ctrl
  import exc_bank_pkg::*;
(
  input  logic              excValid,
  input  logic [TYPE_W-1:0] excType,
  input  logic [MODE_W-1:0] curMode,
  input  logic              modeReq,
  input  logic [MODE_W-1:0] modeNew,
  input  logic              regWrEn,
  output ctrlStrobe_t       strobe
);
  bankSel_t          oldSel;
  bankSel_t          reqSel;
  bankSel_t          tgtSel;
  logic [MODE_W-1:0] tgtMode;
  logic [VEC_W-1:0]  tgtOffset;
  logic              typeOk;

  always_comb begin
    typeOk    = 1'b1;
    tgtMode   = MODE_PRIV;
    tgtOffset = 8'h08;
    case (excType)
      EXC_PRIV_CALL: begin tgtMode = MODE_PRIV; tgtOffset = 8'h08; end
      EXC_ITRAP:     begin tgtMode = MODE_TRAP; tgtOffset = 8'h0C; end
      EXC_DTRAP:     begin tgtMode = MODE_TRAP; tgtOffset = 8'h10; end
      EXC_IRQ:       begin tgtMode = MODE_INTR; tgtOffset = 8'h18; end
      default:       typeOk = 1'b0;
    endcase
  end

  always_comb begin
    oldSel = bankOfMode(curMode);
    reqSel = bankOfMode(modeNew);
    tgtSel = bankOfMode(tgtMode);
    strobe = '0;
    if (excValid) begin
      if (!typeOk || !oldSel.ok) begin
        strobe.raiseErr = 1'b1;
      end else begin
        strobe.enterExc  = 1'b1;
        strobe.swapBanks = (oldSel.idx != tgtSel.idx);
        strobe.oldBank   = oldSel.idx;
        strobe.newBank   = tgtSel.idx;
        strobe.entryMode = tgtMode;
        strobe.vecOffset = tgtOffset;
      end
    end else if (modeReq) begin
      if (!reqSel.ok || !oldSel.ok) begin
        strobe.raiseErr = 1'b1;
      end else begin
        strobe.swapBanks = (oldSel.idx != reqSel.idx);
        strobe.oldBank   = oldSel.idx;
        strobe.newBank   = reqSel.idx;
      end
    end else if (regWrEn) begin
      strobe.writeLive = 1'b1;
    end
  end
endmodule

// File: rtl/exc_bank_dp.sv
module exc_bank_dp
  import exc_bank_pkg::*;
#(
  parameter int                 DATA_W    = 32,
  parameter logic [DATA_W-1:0]  HIGH_BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] curPc,
  input  logic [DATA_W-1:0] curStatus,
  input  logic              highVec,
  input  logic [1:0]        regWrSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] curSp,
  output logic [DATA_W-1:0] curLr,
  output logic [DATA_W-1:0] curSaved,
  output logic [DATA_W-1:0] newPc,
  output logic [DATA_W-1:0] newStatus,
  output logic              fetchFlush,
  output logic              errPulse
);
  logic [DATA_W-1:0] bankSp [BANK_CNT];
  logic [DATA_W-1:0] bankLr [BANK_CNT];
  logic [DATA_W-1:0] bankSv [BANK_CNT];
  logic [DATA_W-1:0] rdSp, rdLr, rdSv;
  logic [DATA_W-1:0] vecAddr;
  logic [DATA_W-1:0] entryStatus;

  always_comb begin
    rdSp = '0;
    rdLr = '0;
    rdSv = '0;
    for (int i = 0; i < BANK_CNT; i++) begin
      if (strobe.newBank == BANK_IDX_W'(i)) begin
        rdSp = bankSp[i];
        rdLr = bankLr[i];
        rdSv = bankSv[i];
      end
    end
  end

  always_comb begin
    vecAddr = {{(DATA_W-VEC_W){1'b0}}, strobe.vecOffset};
    if (highVec) vecAddr = vecAddr + HIGH_BASE;
    entryStatus                 = curStatus;
    entryStatus[MODE_W-1:0]     = strobe.entryMode;
    entryStatus[IRQ_OFF_BIT]    = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < BANK_CNT; i++) begin
        bankSp[i] <= '0;
        bankLr[i] <= '0;
        bankSv[i] <= '0;
      end
    end else if (strobe.swapBanks) begin
      for (int i = 0; i < BANK_CNT; i++) begin
        if (strobe.oldBank == BANK_IDX_W'(i)) begin
          bankSp[i] <= curSp;
          bankLr[i] <= curLr;
          bankSv[i] <= curSaved;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSp      <= '0;
      curLr      <= '0;
      curSaved   <= '0;
      newPc      <= '0;
      newStatus  <= '0;
      fetchFlush <= 1'b0;
      errPulse   <= 1'b0;
    end else begin
      fetchFlush <= strobe.enterExc;
      errPulse   <= strobe.raiseErr;
      if (strobe.enterExc) begin
        if (strobe.swapBanks) curSp <= rdSp;
        curLr     <= curPc;
        curSaved  <= curStatus;
        newPc     <= vecAddr;
        newStatus <= entryStatus;
      end else if (strobe.swapBanks) begin
        curSp    <= rdSp;
        curLr    <= rdLr;
        curSaved <= rdSv;
      end else if (strobe.writeLive) begin
        case (regWrSel)
          2'd0:    curSp    <= regWrData;
          2'd1:    curLr    <= regWrData;
          2'd2:    curSaved <= regWrData;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/exc_bank_unit.sv
module exc_bank_unit
  import exc_bank_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] HIGH_BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excValid,
  input  logic [2:0]        excType,
  input  logic [DATA_W-1:0] curPc,
  input  logic [DATA_W-1:0] curStatus,
  input  logic              highVec,
  input  logic              modeReq,
  input  logic [2:0]        modeNew,
  input  logic              regWrEn,
  input  logic [1:0]        regWrSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] curSp,
  output logic [DATA_W-1:0] curLr,
  output logic [DATA_W-1:0] curSaved,
  output logic [DATA_W-1:0] newPc,
  output logic [DATA_W-1:0] newStatus,
  output logic              fetchFlush,
  output logic              errPulse
);
  ctrlStrobe_t strobe;

  exc_bank_ctrl u_ctrl (
    .excValid (excValid),
    .excType  (excType),
    .curMode  (curStatus[MODE_W-1:0]),
    .modeReq  (modeReq),
    .modeNew  (modeNew),
    .regWrEn  (regWrEn),
    .strobe   (strobe)
  );

  exc_bank_dp #(.DATA_W(DATA_W), .HIGH_BASE(HIGH_BASE)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .curPc      (curPc),
    .curStatus  (curStatus),
    .highVec    (highVec),
    .regWrSel   (regWrSel),
    .regWrData  (regWrData),
    .curSp      (curSp),
    .curLr      (curLr),
    .curSaved   (curSaved),
    .newPc      (newPc),
    .newStatus  (newStatus),
    .fetchFlush (fetchFlush),
    .errPulse   (errPulse)
  );
endmodule

// File: rtl/exc_bank_chk.sv
module exc_bank_chk
  import exc_bank_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] HIGH_BASE = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic              excValid,
  input logic              modeReq,
  input logic              regWrEn,
  input logic              highVec,
  input logic [DATA_W-1:0] curPc,
  input logic [DATA_W-1:0] curStatus,
  input logic [DATA_W-1:0] curSp,
  input logic [DATA_W-1:0] curLr,
  input logic [DATA_W-1:0] curSaved,
  input logic [DATA_W-1:0] newPc,
  input logic [DATA_W-1:0] newStatus,
  input logic              fetchFlush,
  input logic              errPulse
);
  assert_vector_offset_R5: assert property (@(posedge clk) disable iff (!rstN)
    fetchFlush |-> (newPc[7:0] == 8'h08 || newPc[7:0] == 8'h0C ||
                    newPc[7:0] == 8'h10 || newPc[7:0] == 8'h18));

  assert_high_base_R6: assert property (@(posedge clk) disable iff (!rstN)
    fetchFlush |-> (newPc[DATA_W-1:8] ==
                    ($past(highVec) ? HIGH_BASE[DATA_W-1:8] : '0)));

  assert_irq_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    fetchFlush |-> newStatus[IRQ_OFF_BIT]);

  assert_link_pc_R7: assert property (@(posedge clk) disable iff (!rstN)
    fetchFlush |-> curLr == $past(curPc));

  assert_saved_status_R7: assert property (@(posedge clk) disable iff (!rstN)
    fetchFlush |-> curSaved == $past(curStatus));

  assert_flush_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    fetchFlush |-> $past(excValid));

  assert_err_no_change_R9: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> ($stable(curSp) && $stable(curLr) && $stable(curSaved) &&
                  $stable(newPc) && !fetchFlush));

  assert_quiet_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(excValid) && !$past(modeReq) && !$past(regWrEn)) |->
      ($stable(curSp) && $stable(curLr) && $stable(curSaved)));
endmodule

bind exc_bank_unit exc_bank_chk #(.DATA_W(DATA_W), .HIGH_BASE(HIGH_BASE)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .excValid   (excValid),
  .modeReq    (modeReq),
  .regWrEn    (regWrEn),
  .highVec    (highVec),
  .curPc      (curPc),
  .curStatus  (curStatus),
  .curSp      (curSp),
  .curLr      (curLr),
  .curSaved   (curSaved),
  .newPc      (newPc),
  .newStatus  (newStatus),
  .fetchFlush (fetchFlush),
  .errPulse   (errPulse)
);

// File: tb/exc_bank_unit_bench.sv
module exc_bank_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excValid = 1'b0;
  logic [2:0]  excType = '0;
  logic [31:0] curPc = '0;
  logic [31:0] curStatus = '0;
  logic        highVec = 1'b0;
  logic        modeReq = 1'b0;
  logic [2:0]  modeNew = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regWrSel = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] curSp, curLr, curSaved, newPc, newStatus;
  logic        fetchFlush, errPulse;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // bench model
  logic [31:0] mSp [5];
  logic [31:0] mLr [5];
  logic [31:0] mSv [5];
  logic [31:0] lSp, lLr, lSv, ePc, eSt;

  always #2 clk = ~clk;

  exc_bank_unit u_exc_bank_unit (
    .clk(clk), .rstN(rstN), .excValid(excValid), .excType(excType),
    .curPc(curPc), .curStatus(curStatus), .highVec(highVec),
    .modeReq(modeReq), .modeNew(modeNew), .regWrEn(regWrEn),
    .regWrSel(regWrSel), .regWrData(regWrData), .curSp(curSp),
    .curLr(curLr), .curSaved(curSaved), .newPc(newPc),
    .newStatus(newStatus), .fetchFlush(fetchFlush), .errPulse(errPulse)
  );

  function automatic int bankOf(input logic [2:0] m);
    case (m)
      3'd0, 3'd7: return 0;
      3'd3: return 1;
      3'd4: return 2;
      3'd5: return 3;
      3'd2: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag, input logic xFlush, input logic xErr);
    chk(tag, "curSp", curSp, lSp);
    chk(tag, "curLr", curLr, lLr);
    chk(tag, "curSaved", curSaved, lSv);
    chk(tag, "newPc", newPc, ePc);
    chk(tag, "newStatus", newStatus, eSt);
    chk(tag, "fetchFlush", {31'b0, fetchFlush}, {31'b0, xFlush});
    chk(tag, "errPulse", {31'b0, errPulse}, {31'b0, xErr});
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic cycle(input string tag, input logic exc, input logic [2:0] typ,
                       input logic [31:0] pc, input logic hv,
                       input logic mreq, input logic [2:0] mnew,
                       input logic wen, input logic [1:0] wsel, input logic [31:0] wdata);
    logic [2:0]  tm;
    logic [7:0]  off;
    logic [31:0] nextSt;
    logic        xErr, xFlush;
    bit          typeOk;
    int          ob, nb;
    excValid = exc; excType = typ; curPc = pc; highVec = hv;
    modeReq = mreq; modeNew = mnew;
    regWrEn = wen; regWrSel = wsel; regWrData = wdata;
    @(posedge clk);
    xErr = 0; xFlush = 0; nextSt = curStatus;
    ob = bankOf(curStatus[2:0]);
    typeOk = 1; tm = 3'd3; off = 8'h08;
    case (typ)
      3'd0: begin tm = 3'd3; off = 8'h08; end
      3'd1: begin tm = 3'd4; off = 8'h0C; end
      3'd2: begin tm = 3'd4; off = 8'h10; end
      3'd3: begin tm = 3'd2; off = 8'h18; end
      default: typeOk = 0;
    endcase
    if (exc) begin
      if (!typeOk || ob < 0) xErr = 1;
      else begin
        nb = bankOf(tm);
        if (ob != nb) begin
          mSp[ob] = lSp; mLr[ob] = lLr; mSv[ob] = lSv;
          lSp = mSp[nb];
        end
        lLr = pc;
        lSv = curStatus;
        ePc = {24'h0, off} + (hv ? 32'hFFFF_0000 : 32'h0);
        eSt = curStatus;
        eSt[2:0] = tm;
        eSt[7] = 1'b1;
        nextSt = eSt;
        xFlush = 1;
      end
    end else if (mreq) begin
      nb = bankOf(mnew);
      if (nb < 0 || ob < 0) xErr = 1;
      else begin
        if (ob != nb) begin
          mSp[ob] = lSp; mLr[ob] = lLr; mSv[ob] = lSv;
          lSp = mSp[nb]; lLr = mLr[nb]; lSv = mSv[nb];
        end
        nextSt[2:0] = mnew;
      end
    end else if (wen) begin
      case (wsel)
        2'd0: lSp = wdata;
        2'd1: lLr = wdata;
        2'd2: lSv = wdata;
        default: ;
      endcase
    end
    @(negedge clk);
    excValid = 0; modeReq = 0; regWrEn = 0;
    curStatus = nextSt;
    checkAll(tag, xFlush, xErr);
  endtask

  task automatic idle(input string tag);
    cycle(tag, 0, 3'd0, 32'h0, 0, 0, 3'd0, 0, 2'd0, 32'h0);
  endtask

  task automatic wr(input string tag, input logic [1:0] sel, input logic [31:0] d);
    cycle(tag, 0, 3'd0, 32'h0, 0, 0, 3'd0, 1, sel, d);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] validModes [6];
    validModes[0] = 3'd0; validModes[1] = 3'd7; validModes[2] = 3'd3;
    validModes[3] = 3'd4; validModes[4] = 3'd5; validModes[5] = 3'd2;
    for (int i = 0; i < 5; i++) begin mSp[i] = 0; mLr[i] = 0; mSv[i] = 0; end
    lSp = 0; lLr = 0; lSv = 0; ePc = 0; eSt = 0;

    // R1 reset state
    repeat (3) @(negedge clk);
    checkAll("R1", 0, 0);
    rstN = 1'b1;
    idle("R1");

    // R11 live writes, sel 3 ignored
    wr("R11", 2'd0, 32'h1111_0000);
    wr("R11", 2'd1, 32'h2222_0000);
    wr("R11", 2'd2, 32'h3333_0000);
    wr("R11", 2'd3, 32'hDEAD_BEEF);

    // R2 R3 R4 every mode pair with distinct live data
    for (int a = 0; a < 6; a++) begin
      for (int b = 0; b < 6; b++) begin
        curStatus = {29'h0, validModes[a]};
        wr("R11", 2'd0, 32'hA000_0000 + a * 256 + b);
        wr("R11", 2'd1, 32'hB000_0000 + a * 256 + b);
        wr("R11", 2'd2, 32'hC000_0000 + a * 256 + b);
        if (bankOf(validModes[a]) == bankOf(validModes[b]))
          cycle("R4", 0, 3'd0, 32'h0, 0, 1, validModes[b], 0, 2'd0, 32'h0);
        else
          cycle("R3", 0, 3'd0, 32'h0, 0, 1, validModes[b], 0, 2'd0, 32'h0);
      end
    end
    // revisit each mode to read every bank back (R2)
    for (int a = 0; a < 6; a++)
      cycle("R2", 0, 3'd0, 32'h0, 0, 1, validModes[a], 0, 2'd0, 32'h0);

    // R9 invalid requested and current modes
    curStatus = 32'h0000_0003;
    cycle("R9", 0, 3'd0, 32'h0, 0, 1, 3'd1, 0, 2'd0, 32'h0);
    cycle("R9", 0, 3'd0, 32'h0, 0, 1, 3'd6, 0, 2'd0, 32'h0);
    curStatus = 32'h0000_0006;
    cycle("R9", 0, 3'd0, 32'h0, 0, 1, 3'd0, 0, 2'd0, 32'h0);

    // R5 R6 R7 R8 R9 exception sweep: type x highVec x current mode
    for (int t = 0; t < 8; t++) begin
      for (int hv = 0; hv < 2; hv++) begin
        for (int m = 0; m < 8; m++) begin
          logic [31:0] st;
          st = 32'h5A5A_0040 + (t << 12) + (hv << 20);
          st[2:0] = m[2:0];
          curStatus = st;
          if (t > 3 || bankOf(m[2:0]) < 0)
            cycle("R9", 1, t[2:0], 32'h4000 + t * 16 + m * 4, hv[0], 0, 3'd0, 0, 2'd0, 32'h0);
          else if (hv == 1)
            cycle("R6", 1, t[2:0], 32'h4000 + t * 16 + m * 4, 1, 0, 3'd0, 0, 2'd0, 32'h0);
          else if (m == 0)
            cycle("R5", 1, t[2:0], 32'h4000 + t * 16, 0, 0, 3'd0, 0, 2'd0, 32'h0);
          else
            cycle("R7", 1, t[2:0], 32'h4000 + t * 16 + m * 4, 0, 0, 3'd0, 0, 2'd0, 32'h0);
          idle("R8");
        end
      end
    end

    // R8 back-to-back entries flush each cycle
    curStatus = 32'h0000_0005;
    cycle("R8", 1, 3'd3, 32'h8000, 0, 0, 3'd0, 0, 2'd0, 32'h0);
    cycle("R8", 1, 3'd1, 32'h8004, 0, 0, 3'd0, 0, 2'd0, 32'h0);
    idle("R8");

    // R10 priority
    curStatus = 32'h0000_0000;
    cycle("R10", 1, 3'd0, 32'h9000, 0, 1, 3'd5, 1, 2'd0, 32'h7777_7777);
    cycle("R10", 0, 3'd0, 32'h0, 0, 1, 3'd2, 1, 2'd1, 32'h8888_8888);
    cycle("R10", 1, 3'd6, 32'h0, 0, 1, 3'd0, 1, 2'd0, 32'h9999_9999);
    idle("R10");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule